// File: doc/BRIEF.md
# Five-Step Multicycle Load/Store Core

This block is a 32-bit load/store processor core that runs each instruction as a fixed sequence of five steps under a hardwired step counter. The steps are fetch, decode with register read, ALU, memory, and writeback. The steps do not overlap. An instruction that has no work in a step still spends that step idle. The core has a register file with two read ports and one write port. Between the steps it keeps five working registers, which load on every clock: operand A, operand B, ALU result, store data and writeback value. Only the program counter, the instruction register, register-file writes and memory writes have enables.

The core has one memory port, shared by instruction fetch and data access. A step that touches memory raises a read or write request and holds it, with a stable address, until the memory returns a completion pulse. Only then does the step counter advance. A memory of any latency can be attached in this way, including one that completes in the same cycle.

The step counter has five named states: STEP_FETCH, STEP_DECODE, STEP_EXEC, STEP_MEM and STEP_WB. Its transitions are:
- STEP_FETCH goes to STEP_DECODE on completion and waits otherwise.
- STEP_DECODE goes to STEP_EXEC, and STEP_EXEC goes to STEP_MEM, with no condition.
- STEP_MEM goes to STEP_WB when the instruction needs no data access or when the data access completes. It waits otherwise.
- STEP_WB wraps to STEP_FETCH.

Top module: `step5_core`

## Requirements
- R1: Each instruction spends exactly one cycle in each of STEP_DECODE, STEP_EXEC and STEP_WB. It spends at least one cycle in STEP_FETCH. It spends at least one cycle in STEP_MEM, and more only while a data access waits. Completing a fetch adds 4 to the program counter, so programs without jumps fetch at consecutive word addresses.
- R2: The instruction word is laid out as follows:
  - bits [31:26] opcode;
  - bits [25:21] field A (first source, or base);
  - bits [20:16] field B (second source, store data, or destination of an immediate-form instruction);
  - bits [15:11] field C (destination of a register-form instruction);
  - bits [15:0] a 16-bit immediate, sign-extended to 32 bits.
  The opcodes are: add 1, sub 2, and 3, or 4, add-immediate 5, load 6, store 7, jump 8, jump-if-equal 9, call-through-register 10.
- R3: `mem_rd` and `mem_wr` are never high together. The address is the program counter during fetch and the ALU result during a data access.
- R4: A store writes register B to address reg[A]+imm during STEP_MEM.
- R5: add, sub, and and or compute reg[A] op reg[B] into register C. Add-immediate computes reg[A]+imm into register B.
- R6: A load reads address reg[A]+imm and writes the returned word into register B.
- R7: Jump and taken jump-if-equal both set the program counter to (address of the instruction + 4) + imm. Jump-if-equal is taken only when reg[A] equals reg[B].
- R8: While `mem_done` is low, a raised request, its address and the step counter all hold. Each wait cycle adds one cycle to the instruction.
- R9: Call-through-register sets the program counter to reg[A] and writes the return address (address of the call + 4) into register 31.
- R10: Register 0 reads as zero, and writes to it are discarded.
- R11: An undefined opcode spends all five steps and changes nothing except the program counter's normal advance by 4.
- R12: Synchronous reset clears the program counter to 0 and the step counter to STEP_FETCH, so the first request is a read of address 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| mem_addr | output | 32 | Byte address for the current access |
| mem_rd | output | 1 | Read request (fetch or load) |
| mem_wr | output | 1 | Write request (store) |
| mem_wdata | output | 32 | Store data |
| mem_rdata | input | 32 | Read data, valid with mem_done |
| mem_done | input | 1 | Access complete in this cycle |

## Verification
The bus sequence exposes all internal state. A wrong ALU, selector or register-file value appears as a wrong store address or store data. A wrong program-counter update appears as a wrong fetch address. Both show up within the five steps of the faulty instruction, or at the first later store that reads the corrupted register. A step counter that skips or repeats a step shows up as a wrong number of cycles between two fetch completions, even when every value is correct.

// File: rtl/step5_pkg.sv
package step5_pkg;

    localparam int OPC_W = 6;
    localparam int RIDX_W = 5;
    localparam int IMM_W = 16;

    localparam logic [OPC_W-1:0] OPC_ADD   = 6'd1;
    localparam logic [OPC_W-1:0] OPC_SUB   = 6'd2;
    localparam logic [OPC_W-1:0] OPC_AND   = 6'd3;
    localparam logic [OPC_W-1:0] OPC_OR    = 6'd4;
    localparam logic [OPC_W-1:0] OPC_ADDI  = 6'd5;
    localparam logic [OPC_W-1:0] OPC_LOAD  = 6'd6;
    localparam logic [OPC_W-1:0] OPC_STORE = 6'd7;
    localparam logic [OPC_W-1:0] OPC_JMP   = 6'd8;
    localparam logic [OPC_W-1:0] OPC_JEQ   = 6'd9;
    localparam logic [OPC_W-1:0] OPC_CALLR = 6'd10;

    typedef enum logic [2:0] {
        STEP_FETCH, STEP_DECODE, STEP_EXEC, STEP_MEM, STEP_WB
    } step_e;

    typedef enum logic [1:0] { ALU_ADD, ALU_SUB, ALU_AND, ALU_OR } alu_op_e;
    typedef enum logic [1:0] { RES_ALU, RES_MEM, RES_RET } res_sel_e;
    typedef enum logic [1:0] { DST_C, DST_B, DST_LINK } dst_sel_e;

    typedef struct packed {
        alu_op_e  alu_op;
        logic     use_imm;
        res_sel_e res_sel;
        dst_sel_e dst_sel;
        logic     rf_we;
        logic     ld;
        logic     st;
        logic     jmp;
        logic     jeq;
        logic     call;
    } ctl_t;

    function automatic ctl_t decode_op(input logic [OPC_W-1:0] op);
        ctl_t c;
        c = '{alu_op: ALU_ADD, use_imm: 1'b0, res_sel: RES_ALU, dst_sel: DST_C,
              rf_we: 1'b0, ld: 1'b0, st: 1'b0, jmp: 1'b0, jeq: 1'b0, call: 1'b0};
        case (op)
            OPC_ADD:   c.rf_we = 1'b1;
            OPC_SUB:   begin c.rf_we = 1'b1; c.alu_op = ALU_SUB; end
            OPC_AND:   begin c.rf_we = 1'b1; c.alu_op = ALU_AND; end
            OPC_OR:    begin c.rf_we = 1'b1; c.alu_op = ALU_OR;  end
            OPC_ADDI:  begin c.rf_we = 1'b1; c.use_imm = 1'b1; c.dst_sel = DST_B; end
            OPC_LOAD:  begin c.rf_we = 1'b1; c.use_imm = 1'b1; c.dst_sel = DST_B;
                             c.res_sel = RES_MEM; c.ld = 1'b1; end
            OPC_STORE: begin c.use_imm = 1'b1; c.st = 1'b1; end
            OPC_JMP:   c.jmp = 1'b1;
            OPC_JEQ:   c.jeq = 1'b1;
            OPC_CALLR: begin c.rf_we = 1'b1; c.call = 1'b1; c.res_sel = RES_RET;
                             c.dst_sel = DST_LINK; end
            default:   ;
        endcase
        return c;
    endfunction

endpackage

// File: rtl/step5_regfile.sv
module step5_regfile #(
    parameter int W = 32,
    parameter int N = 32,
    localparam int AW = $clog2(N)
) (
    input  logic          clk,
    input  logic [AW-1:0] ra_addr,
    input  logic [AW-1:0] rb_addr,
    output logic [W-1:0]  ra_data,
    output logic [W-1:0]  rb_data,
    input  logic          we,
    input  logic [AW-1:0] wa,
    input  logic [W-1:0]  wd
);
    logic [W-1:0] regs [N];

    always_ff @(posedge clk) begin
        if (we && wa != '0) begin
            regs[wa] <= wd;
        end
    end

    assign ra_data = (ra_addr == '0) ? '0 : regs[ra_addr];
    assign rb_data = (rb_addr == '0) ? '0 : regs[rb_addr];

endmodule

// File: rtl/step5_alu.sv
module step5_alu
    import step5_pkg::*;
#(
    parameter int W = 32
) (
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    input  alu_op_e      op,
    output logic [W-1:0] y
);
    always_comb begin
        unique case (op)
            ALU_ADD: y = a + b;
            ALU_SUB: y = a - b;
            ALU_AND: y = a & b;
            ALU_OR:  y = a | b;
            default: y = a + b;
        endcase
    end
endmodule

// File: rtl/step5_ctrl.sv
module step5_ctrl
    import step5_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  need_data,
    input  logic  mem_done,
    output step_e step,
    output logic  fetch_ph,
    output logic  exec_ph,
    output logic  mem_ph,
    output logic  wb_ph
);
    step_e step_nx;

    always_ff @(posedge clk) begin
        if (rst) begin
            step <= STEP_FETCH;
        end else begin
            step <= step_nx;
        end
    end

    always_comb begin
        unique case (step)
            STEP_FETCH:  step_nx = mem_done ? STEP_DECODE : STEP_FETCH;
            STEP_DECODE: step_nx = STEP_EXEC;
            STEP_EXEC:   step_nx = STEP_MEM;
            STEP_MEM:    step_nx = (!need_data || mem_done) ? STEP_WB : STEP_MEM;
            STEP_WB:     step_nx = STEP_FETCH;
            default:     step_nx = STEP_FETCH;
        endcase
    end

    always_comb begin
        fetch_ph = 1'b0;
        exec_ph  = 1'b0;
        mem_ph   = 1'b0;
        wb_ph    = 1'b0;
        unique case (step)
            STEP_FETCH:  fetch_ph = 1'b1;
            STEP_DECODE: ;
            STEP_EXEC:   exec_ph = 1'b1;
            STEP_MEM:    mem_ph = 1'b1;
            STEP_WB:     wb_ph = 1'b1;
            default:     ;
        endcase
    end

    AST_STALL_HOLDS_STEP: assert property (@(posedge clk) disable iff (rst)
        ((step == STEP_FETCH || (step == STEP_MEM && need_data)) && !mem_done)
        |=> $stable(step)); // R8

endmodule

// File: rtl/step5_core.sv
module step5_core
    import step5_pkg::*;
#(
    parameter int XLEN = 32,
    parameter int NREGS = 32,
    localparam int AW = $clog2(NREGS)
) (
    input  logic            clk,
    input  logic            rst,
    output logic [XLEN-1:0] mem_addr,
    output logic            mem_rd,
    output logic            mem_wr,
    output logic [XLEN-1:0] mem_wdata,
    input  logic [XLEN-1:0] mem_rdata,
    input  logic            mem_done
);
    localparam logic [AW-1:0] LINK_IDX = AW'(NREGS - 1);

    logic [XLEN-1:0] pc_q, ir_q;
    logic [XLEN-1:0] opa_q, opb_q, res_q, sdat_q, wbv_q, ret_q;
    logic [XLEN-1:0] rf_a, rf_b, imm_ext, alu_b, alu_y;
    logic [AW-1:0]   dst_idx;
    logic            rf_we;
    logic            fetch_ph, exec_ph, mem_ph, wb_ph;
    step_e           step;
    ctl_t            ctl;

    assign ctl     = decode_op(ir_q[31:26]);
    assign imm_ext = {{(XLEN-IMM_W){ir_q[IMM_W-1]}}, ir_q[IMM_W-1:0]};
    assign alu_b   = ctl.use_imm ? imm_ext : opb_q;

    step5_ctrl u_ctrl (
        .clk(clk), .rst(rst), .need_data(ctl.ld | ctl.st), .mem_done(mem_done),
        .step(step), .fetch_ph(fetch_ph), .exec_ph(exec_ph), .mem_ph(mem_ph), .wb_ph(wb_ph)
    );

    step5_regfile #(.W(XLEN), .N(NREGS)) u_rf (
        .clk(clk), .ra_addr(ir_q[25:21]), .rb_addr(ir_q[20:16]),
        .ra_data(rf_a), .rb_data(rf_b), .we(rf_we), .wa(dst_idx), .wd(wbv_q)
    );

    step5_alu #(.W(XLEN)) u_alu (.a(opa_q), .b(alu_b), .op(ctl.alu_op), .y(alu_y));

    // Working registers between steps load on every clock.
    always_ff @(posedge clk) begin
        opa_q  <= rf_a;
        opb_q  <= rf_b;
        res_q  <= alu_y;
        sdat_q <= opb_q;
        ret_q  <= pc_q;
        unique case (ctl.res_sel)
            RES_ALU: wbv_q <= res_q;
            RES_MEM: wbv_q <= mem_rdata;
            RES_RET: wbv_q <= ret_q;
            default: wbv_q <= res_q;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            pc_q <= '0;
            ir_q <= '0;
        end else if (fetch_ph && mem_done) begin
            pc_q <= pc_q + XLEN'(4);
            ir_q <= mem_rdata;
        end else if (exec_ph) begin
            if (ctl.jmp || (ctl.jeq && opa_q == opb_q)) begin
                pc_q <= pc_q + imm_ext;
            end else if (ctl.call) begin
                pc_q <= opa_q;
            end
        end
    end

    always_comb begin
        unique case (ctl.dst_sel)
            DST_C:    dst_idx = ir_q[15:11];
            DST_B:    dst_idx = ir_q[20:16];
            DST_LINK: dst_idx = LINK_IDX;
            default:  dst_idx = ir_q[15:11];
        endcase
    end

    assign rf_we     = wb_ph && ctl.rf_we;
    assign mem_addr  = fetch_ph ? pc_q : res_q;
    assign mem_rd    = fetch_ph || (mem_ph && ctl.ld);
    assign mem_wr    = mem_ph && ctl.st;
    assign mem_wdata = sdat_q;

    AST_ONE_REQUEST: assert property (@(posedge clk) disable iff (rst)
        !(mem_rd && mem_wr)); // R3

    AST_REQ_HELD: assert property (@(posedge clk) disable iff (rst)
        ((mem_rd || mem_wr) && !mem_done) |=> ((mem_rd || mem_wr) && $stable(mem_addr))); // R8

    AST_WB_FOLLOWS_MEM: assert property (@(posedge clk) disable iff (rst)
        rf_we |-> ($past(step) == STEP_MEM)); // R1

    AST_FETCH_ADVANCES_PC: assert property (@(posedge clk) disable iff (rst)
        (fetch_ph && mem_done) |=> (pc_q == $past(pc_q) + XLEN'(4))); // R1

endmodule

// File: tb/step5_core_bench.sv
module step5_core_bench;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [31:0] mem_addr, mem_wdata;
    logic [31:0] mem_rdata = '0;
    logic        mem_rd, mem_wr;
    logic        mem_done = 1'b0;

    always #2.5 clk = ~clk;

    step5_core u_step5_core (
        .clk(clk), .rst(rst), .mem_addr(mem_addr), .mem_rd(mem_rd), .mem_wr(mem_wr),
        .mem_wdata(mem_wdata), .mem_rdata(mem_rdata), .mem_done(mem_done)
    );

    int n_checks = 0;
    int n_fails = 0;
    int cyc = 0;

    logic [31:0] img [256];

    // Scoreboard queues: kind 0 fetch, 1 data read, 2 data write.
    int          q_kind [$];
    logic [31:0] q_addr [$];
    logic [31:0] q_data [$];
    string       q_tag  [$];

    task automatic push(input int kind, input logic [31:0] a, input logic [31:0] d, input string tag);
        q_kind.push_back(kind);
        q_addr.push_back(a);
        q_data.push_back(d);
        q_tag.push_back(tag);
    endtask

    task automatic check(input bit ok, input string tag, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (!ok) begin
            n_fails++;
            $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
        end
    endtask

    // Field layout per R2.
    function automatic logic [31:0] rform(input int op, input int c, input int a, input int b);
        return {op[5:0], a[4:0], b[4:0], c[4:0], 11'd0};
    endfunction
    function automatic logic [31:0] iform(input int op, input int b, input int a, input int imm);
        return {op[5:0], a[4:0], b[4:0], imm[15:0]};
    endfunction

    always @(posedge clk) cyc <= cyc + 1;

    // Memory model and monitor. Latency of transaction t is t % 3 wait cycles.
    int txn = 0;
    int wcnt = 0;
    int lat_acc = 0;
    int last_fetch = -1;

    always @(negedge clk) begin
        if (rst) begin
            mem_done = 1'b0;
            wcnt = 0;
        end else begin
            if (mem_done) begin
                mem_done = 1'b0;
                txn++;
                wcnt = 0;
            end
            if (mem_rd || mem_wr) begin
                if (wcnt == txn % 3) begin
                    mem_done = 1'b1;
                    lat_acc += txn % 3;
                    if (mem_wr) img[mem_addr[9:2]] = mem_wdata;
                    else mem_rdata = img[mem_addr[9:2]];
                    if (q_kind.size() == 0) begin
                        check(1'b0, "R1", "unexpected bus access", mem_addr, 32'h0);
                    end else begin
                        int k;
                        logic [31:0] ea, ed;
                        string tg;
                        k = q_kind.pop_front();
                        ea = q_addr.pop_front();
                        ed = q_data.pop_front();
                        tg = q_tag.pop_front();
                        check(mem_wr == (k == 2), tg, "access direction", {31'd0, mem_wr}, {31'd0, k == 2});
                        check(mem_addr == ea, tg, "access address", mem_addr, ea);
                        if (k == 2) check(mem_wdata == ed, tg, "store data", mem_wdata, ed);
                        if (k == 0) begin
                            if (last_fetch >= 0)
                                check(cyc - last_fetch == 5 + lat_acc, "R8",
                                      "cycles between fetches", 32'(cyc - last_fetch), 32'(5 + lat_acc));
                            last_fetch = cyc;
                            lat_acc = 0;
                        end
                    end
                end else begin
                    wcnt++;
                end
            end
        end
    end

    initial begin
        for (int i = 0; i < 256; i++) img[i] = 32'h0;
        img[0]  = iform(5, 1, 0, 5);          // r1 = 5
        img[1]  = iform(5, 2, 0, -3);         // r2 = -3
        img[2]  = rform(1, 3, 1, 2);          // r3 = 2
        img[3]  = rform(2, 4, 1, 2);          // r4 = 8
        img[4]  = rform(3, 5, 1, 2);          // r5 = 5
        img[5]  = rform(4, 6, 1, 2);          // r6 = fffffffd
        img[6]  = iform(7, 3, 0, 'h100);
        img[7]  = iform(7, 4, 0, 'h104);
        img[8]  = iform(7, 5, 0, 'h108);
        img[9]  = iform(7, 6, 0, 'h10C);
        img[10] = iform(6, 7, 0, 'h200);      // load r7
        img[11] = iform(7, 7, 0, 'h110);
        img[12] = iform(5, 0, 0, 7);          // write to r0
        img[13] = iform(7, 0, 0, 'h114);
        img[14] = iform(9, 2, 1, 8);          // not taken
        img[15] = iform(9, 1, 1, 8);          // taken -> 72
        img[16] = iform(7, 1, 0, 'h118);      // skipped
        img[18] = iform(8, 0, 0, 8);          // jump -> 84
        img[19] = iform(7, 1, 0, 'h118);      // skipped
        img[20] = iform(7, 1, 0, 'h118);      // skipped
        img[21] = iform(5, 8, 0, 96);         // r8 = 96
        img[22] = iform(10, 0, 8, 0);         // call r8
        img[23] = iform(7, 1, 0, 'h124);      // skipped
        img[24] = iform(7, 31, 0, 'h11C);     // store link
        img[25] = 32'hFC00_0000;              // undefined opcode 63
        img[26] = iform(7, 1, 0, 'h120);
        img[27] = iform(8, 0, 0, -4);         // self loop
        img[128] = 32'h1234_5678;

        push(0, 0,  0, "R12"); push(0, 4, 0, "R1"); push(0, 8, 0, "R1");
        push(0, 12, 0, "R1"); push(0, 16, 0, "R1"); push(0, 20, 0, "R1");
        push(0, 24, 0, "R1"); push(2, 'h100, 32'd2, "R5");
        push(0, 28, 0, "R1"); push(2, 'h104, 32'd8, "R5");
        push(0, 32, 0, "R1"); push(2, 'h108, 32'd5, "R5");
        push(0, 36, 0, "R1"); push(2, 'h10C, 32'hFFFF_FFFD, "R4");
        push(0, 40, 0, "R1"); push(1, 'h200, 0, "R6");
        push(0, 44, 0, "R1"); push(2, 'h110, 32'h1234_5678, "R6");
        push(0, 48, 0, "R1"); push(0, 52, 0, "R1"); push(2, 'h114, 32'd0, "R10");
        push(0, 56, 0, "R7"); push(0, 60, 0, "R7"); push(0, 72, 0, "R7");
        push(0, 84, 0, "R7"); push(0, 88, 0, "R1"); push(0, 96, 0, "R9");
        push(2, 'h11C, 32'd92, "R9");
        push(0, 100, 0, "R1"); push(0, 104, 0, "R11"); push(2, 'h120, 32'd5, "R11");
        push(0, 108, 0, "R1"); push(0, 108, 0, "R7");

        repeat (2) @(posedge clk);
        @(negedge clk);
        check(mem_rd == 1'b1 && mem_wr == 1'b0, "R12", "reset request", {30'd0, mem_rd, mem_wr}, 32'h2);
        check(mem_addr == 32'h0, "R12", "reset address", mem_addr, 32'h0);
        rst = 1'b0;

        fork
            wait (q_kind.size() == 0);
            begin
                repeat (5000) @(posedge clk);
                check(1'b0, "R1", "watchdog expired", 32'(q_kind.size()), 32'h0);
            end
        join_any
        #1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
        $finish;
    end

endmodule